// File: doc/BRIEF.md
# Dual Receive Buffer Controller

This block sits behind the frame assembler of a CAN-style receiver. The assembler keeps one staging area for the frame it is currently collecting. When that frame completes, or breaks off with an error before its end, the controller decides whether to copy it into one of two holding buffers. Buffer 0 has the higher priority and buffer 1 the lower. The filter logic outside the block supplies one accept result and one filter index for each buffer. The controller combines these with a per-buffer receive mode and with the occupancy of each buffer. In the same clock edge it copies the staged frame, whole, into the chosen holding buffer.

Each holding buffer is locked by a full flag that only the host can release. While the flag is set, the buffer's contents never change. A frame that finds its target locked is dropped, and a sticky overflow flag is raised. An optional rollover path avoids that loss for high-priority traffic: a frame meant for the locked buffer 0 goes into buffer 1, and buffer 1's own filter result is not consulted. The host reads either buffer through one read port selected by a single bit. An interrupt request for each buffer follows its full flag, gated by that buffer's enable.

Top module: `rxb_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `full`, `ovf` and `irq` are all zero.
- R2: A frame admitted to a buffer overwrites every field of that buffer (identifier, extended flag, remote flag, length code, data) and stores the filter index. The buffer's `full` bit reads 1 in the cycle after the strobe edge.
- R3: The receive mode of each buffer works as follows. 2'b00 admits when the buffer's accept bit is set. 2'b01 also requires `stage_ext`=0. 2'b10 also requires `stage_ext`=1. 2'b11 admits every frame whatever the accept bit, and still stores that buffer's index input.
- R4: While a buffer's `full` bit is 1, no frame is loaded into it and its contents hold. A one-cycle pulse on its `clr_full` bit makes `full` read 0 in the next cycle.
- R5: `irq[n]` is 1 exactly when `full[n]` and `irq_en[n]` are both 1.
- R6: A frame admitted to both buffers while buffer 0 is free goes to buffer 0 only.
- R7: With `roll_en`=1, a frame admitted to buffer 0 while buffer 0 is full and buffer 1 is free goes into buffer 1, whatever buffer 1's mode and accept bit. It stores buffer 0's filter index and raises no overflow.
- R8: With `roll_en`=0, a frame admitted to a full buffer 0 is loaded into buffer 1 when buffer 1 admits it and is free.
- R9: The `frame_err` strobe loads a buffer only when that buffer's mode is 2'b11. Otherwise it has no effect.
- R10: A dropped frame sets the sticky `ovf` bit of each full buffer that admitted it. A frame dropped on the rollover path sets `ovf[1]` only. A pulse on a `clr_ovf` bit clears the matching `ovf` bit in the next cycle.
- R11: `rd_sel`=0 presents buffer 0 on the `rd_*` outputs and `rd_sel`=1 presents buffer 1. The path from `rd_sel` to the outputs is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | Staged frame completed (one-cycle strobe) |
| frame_err | input | 1 | Staged frame hit an error before its end (one-cycle strobe) |
| stage_id | input | 29 | Staged identifier |
| stage_ext | input | 1 | Staged frame uses an extended identifier |
| stage_rtr | input | 1 | Staged frame is a remote request |
| stage_dlc | input | 4 | Staged length code |
| stage_data | input | 64 | Staged data bytes |
| acc_hit | input | 2 | Filter accept result for each buffer |
| acc_idx0 | input | 3 | Index of the filter that matched for buffer 0 |
| acc_idx1 | input | 3 | Index of the filter that matched for buffer 1 |
| mode0 | input | 2 | Receive mode of buffer 0 |
| mode1 | input | 2 | Receive mode of buffer 1 |
| roll_en | input | 1 | Enable rollover from buffer 0 into buffer 1 |
| irq_en | input | 2 | Interrupt enable for each buffer |
| clr_full | input | 2 | Host release of each buffer's full flag |
| clr_ovf | input | 2 | Host clear of each overflow flag |
| rd_sel | input | 1 | Buffer shown on the read port |
| full | output | 2 | Buffer locked, holding a frame |
| irq | output | 2 | Interrupt request for each buffer |
| ovf | output | 2 | Sticky overflow for each buffer |
| rd_id | output | 29 | Read port: identifier |
| rd_ext | output | 1 | Read port: extended flag |
| rd_rtr | output | 1 | Read port: remote flag |
| rd_dlc | output | 4 | Read port: length code |
| rd_data | output | 64 | Read port: data |
| rd_fidx | output | 3 | Read port: stored filter index |

## Verification
The properties assume the following about the inputs:
- `frame_done` and `frame_err` are never high in the same cycle.
- The accept bits and indices are only meaningful in a strobe cycle.
- A host clear may coincide with a load but never replaces one.

The stimulus drives each strobe for exactly one cycle, from the falling clock edge. It never raises both strobes together, and it returns the accept bits to zero after each frame. Clear pulses are only issued in cycles with no strobe, so every load or drop is seen with the flags that the previous cycle left behind.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int ID_W   = 29;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int FIDX_W = 3;
    localparam int NBUF   = 2;
    localparam int SEL_W  = (NBUF > 1) ? $clog2(NBUF) : 1;

    typedef enum logic [1:0] {
        RXM_FILTER = 2'b00,
        RXM_STD    = 2'b01,
        RXM_EXT    = 2'b10,
        RXM_ALL    = 2'b11
    } rx_mode_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ext;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } rx_frame_t;

    typedef struct packed {
        logic [NBUF-1:0] load;
        logic [NBUF-1:0] ovf_set;
        logic            rolled;
    } route_t;

    // Does one buffer take the staged frame, judged on its own mode and filter?
    function automatic logic admits(input rx_mode_e m, input logic acc,
                                    input logic ext, input logic done,
                                    input logic err);
        logic r;
        r = 1'b0;
        unique case (m)
            RXM_FILTER: r = done & acc;
            RXM_STD:    r = done & acc & ~ext;
            RXM_EXT:    r = done & acc & ext;
            RXM_ALL:    r = done | err;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxb_route.sv
module rxb_route
    import rxb_pkg::*;
(
    input  logic            done,
    input  logic            err,
    input  logic            ext,
    input  logic [NBUF-1:0] acc,
    input  rx_mode_e        mode0,
    input  rx_mode_e        mode1,
    input  logic [NBUF-1:0] full,
    input  logic            roll_en,
    output route_t          rt
);

    logic want0, want1;

    always_comb begin
        want0 = admits(mode0, acc[0], ext, done, err);
        want1 = admits(mode1, acc[1], ext, done, err);
        rt    = '0;
        if (want0 && !full[0]) begin
            rt.load[0] = 1'b1;
        end else if (want0) begin
            if (roll_en) begin
                // rollover: buffer 1's own check is bypassed
                if (!full[1]) begin
                    rt.load[1] = 1'b1;
                    rt.rolled  = 1'b1;
                end else begin
                    rt.ovf_set[1] = 1'b1;
                end
            end else if (want1 && !full[1]) begin
                rt.load[1] = 1'b1;
            end else begin
                rt.ovf_set[0] = 1'b1;
                rt.ovf_set[1] = want1;
            end
        end else if (want1) begin
            if (!full[1]) rt.load[1] = 1'b1;
            else          rt.ovf_set[1] = 1'b1;
        end
    end

endmodule

// File: rtl/rxb_slot.sv
module rxb_slot
    import rxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  rx_frame_t         din,
    input  logic [FIDX_W-1:0] fidx_in,
    input  logic              clr_full,
    input  logic              ovf_set,
    input  logic              clr_ovf,
    output logic              full,
    output logic              ovf,
    output rx_frame_t         held,
    output logic [FIDX_W-1:0] fidx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            ovf  <= 1'b0;
            held <= '0;
            fidx <= '0;
        end else begin
            if (load) begin
                held <= din;
                fidx <= fidx_in;
                full <= 1'b1;
            end else if (clr_full) begin
                full <= 1'b0;
            end
            if (ovf_set)      ovf <= 1'b1;
            else if (clr_ovf) ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
    import rxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  logic              frame_err,
    input  logic [ID_W-1:0]   stage_id,
    input  logic              stage_ext,
    input  logic              stage_rtr,
    input  logic [DLC_W-1:0]  stage_dlc,
    input  logic [DATA_W-1:0] stage_data,
    input  logic [NBUF-1:0]   acc_hit,
    input  logic [FIDX_W-1:0] acc_idx0,
    input  logic [FIDX_W-1:0] acc_idx1,
    input  logic [1:0]        mode0,
    input  logic [1:0]        mode1,
    input  logic              roll_en,
    input  logic [NBUF-1:0]   irq_en,
    input  logic [NBUF-1:0]   clr_full,
    input  logic [NBUF-1:0]   clr_ovf,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [NBUF-1:0]   full,
    output logic [NBUF-1:0]   irq,
    output logic [NBUF-1:0]   ovf,
    output logic [ID_W-1:0]   rd_id,
    output logic              rd_ext,
    output logic              rd_rtr,
    output logic [DLC_W-1:0]  rd_dlc,
    output logic [DATA_W-1:0] rd_data,
    output logic [FIDX_W-1:0] rd_fidx
);

    rx_frame_t         staged;
    route_t            rt;
    rx_frame_t         held_w [NBUF];
    logic [FIDX_W-1:0] fidx_w [NBUF];
    logic [FIDX_W-1:0] idx_in [NBUF];
    rx_frame_t         rd_frame;

    always_comb begin
        staged.id   = stage_id;
        staged.ext  = stage_ext;
        staged.rtr  = stage_rtr;
        staged.dlc  = stage_dlc;
        staged.data = stage_data;
    end

    rxb_route u_route (
        .done    (frame_done),
        .err     (frame_err),
        .ext     (stage_ext),
        .acc     (acc_hit),
        .mode0   (rx_mode_e'(mode0)),
        .mode1   (rx_mode_e'(mode1)),
        .full    (full),
        .roll_en (roll_en),
        .rt      (rt)
    );

    // a rolled frame keeps the index of the buffer-0 filter that matched
    always_comb begin
        idx_in[0] = acc_idx0;
        idx_in[1] = rt.rolled ? acc_idx0 : acc_idx1;
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        rxb_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .load     (rt.load[g]),
            .din      (staged),
            .fidx_in  (idx_in[g]),
            .clr_full (clr_full[g]),
            .ovf_set  (rt.ovf_set[g]),
            .clr_ovf  (clr_ovf[g]),
            .full     (full[g]),
            .ovf      (ovf[g]),
            .held     (held_w[g]),
            .fidx     (fidx_w[g])
        );
        assign irq[g] = full[g] & irq_en[g];
    end

    always_comb begin
        rd_frame = held_w[rd_sel];
        rd_fidx  = fidx_w[rd_sel];
        rd_id    = rd_frame.id;
        rd_ext   = rd_frame.ext;
        rd_rtr   = rd_frame.rtr;
        rd_dlc   = rd_frame.dlc;
        rd_data  = rd_frame.data;
    end

endmodule

// File: rtl/rxb_ctrl_chk.sv
module rxb_ctrl_chk
    import rxb_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            frame_done,
    input logic            frame_err,
    input logic [NBUF-1:0] acc_hit,
    input logic [1:0]      mode0,
    input logic [1:0]      mode1,
    input logic            roll_en,
    input logic [NBUF-1:0] clr_full,
    input logic [NBUF-1:0] clr_ovf,
    input logic [NBUF-1:0] full,
    input logic [NBUF-1:0] ovf,
    input logic [NBUF-1:0] irq,
    input rx_frame_t       held0,
    input rx_frame_t       held1
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (full == '0 && ovf == '0 && irq == '0));

    a_r4_lock0: assert property (@(posedge clk) disable iff (rst)
        (full[0] && !clr_full[0]) |=> (full[0] && $stable(held0)));

    a_r4_lock1: assert property (@(posedge clk) disable iff (rst)
        (full[1] && !clr_full[1]) |=> (full[1] && $stable(held1)));

    a_r5_irq0: assert property (@(posedge clk) disable iff (rst)
        irq[0] |-> full[0]);

    a_r5_irq1: assert property (@(posedge clk) disable iff (rst)
        irq[1] |-> full[1]);

    a_r6_prio: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !frame_err && acc_hit == 2'b11 && mode0 == 2'b00 &&
         mode1 == 2'b00 && !full[0]) |=> (full[0] && $stable(held1)));

    a_r7_rollover: assert property (@(posedge clk) disable iff (rst)
        (roll_en && frame_done && !frame_err && acc_hit[0] && mode0 == 2'b00 &&
         full[0] && !full[1]) |=> (full[1] && !$rose(ovf[0])));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!frame_done && !frame_err) |=> ($stable(held0) && $stable(held1)));

    a_r10_sticky0: assert property (@(posedge clk) disable iff (rst)
        (ovf[0] && !clr_ovf[0]) |=> ovf[0]);

    a_r10_sticky1: assert property (@(posedge clk) disable iff (rst)
        (ovf[1] && !clr_ovf[1]) |=> ovf[1]);

endmodule

bind rxb_ctrl rxb_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .frame_err  (frame_err),
    .acc_hit    (acc_hit),
    .mode0      (mode0),
    .mode1      (mode1),
    .roll_en    (roll_en),
    .clr_full   (clr_full),
    .clr_ovf    (clr_ovf),
    .full       (full),
    .ovf        (ovf),
    .irq        (irq),
    .held0      (held_w[0]),
    .held1      (held_w[1])
);

// File: tb/rxb_ctrl_test.sv
module rxb_ctrl_test;
    import rxb_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_done = 1'b0, frame_err = 1'b0;
    logic [ID_W-1:0]   stage_id = '0;
    logic              stage_ext = 1'b0, stage_rtr = 1'b0;
    logic [DLC_W-1:0]  stage_dlc = '0;
    logic [DATA_W-1:0] stage_data = '0;
    logic [1:0]        acc_hit = '0;
    logic [2:0]        acc_idx0 = '0, acc_idx1 = '0;
    logic [1:0]        mode0 = 2'b00, mode1 = 2'b00;
    logic              roll_en = 1'b0;
    logic [1:0]        irq_en = '0, clr_full = '0, clr_ovf = '0;
    logic              rd_sel = 1'b0;
    logic [1:0]        full, irq, ovf;
    logic [ID_W-1:0]   rd_id;
    logic              rd_ext, rd_rtr;
    logic [DLC_W-1:0]  rd_dlc;
    logic [DATA_W-1:0] rd_data;
    logic [2:0]        rd_fidx;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int                bsel;
        logic [ID_W-1:0]   id;
        logic              ext;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
        logic [2:0]        fidx;
    } exp_t;

    exp_t q[$];

    rxb_ctrl uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one strobe cycle, expectation pushed before the edge
    task automatic send(input logic d, input logic e, input logic [ID_W-1:0] id,
                        input logic x, input logic r, input logic [3:0] dl,
                        input logic [63:0] dat, input logic a0, input logic [2:0] i0,
                        input logic a1, input logic [2:0] i1, input int eb,
                        input logic [2:0] ei);
        exp_t it;
        if (eb >= 0) begin
            it.bsel = eb; it.id = id; it.ext = x; it.rtr = r;
            it.dlc = dl; it.data = dat; it.fidx = ei;
            q.push_back(it);
        end
        frame_done = d; frame_err = e; stage_id = id; stage_ext = x;
        stage_rtr = r; stage_dlc = dl; stage_data = dat;
        acc_hit = {a1, a0}; acc_idx0 = i0; acc_idx1 = i1;
        @(posedge clk);
        @(negedge clk);
        frame_done = 1'b0; frame_err = 1'b0; acc_hit = '0;
    endtask

    task automatic pulse(input logic [1:0] cf, input logic [1:0] co);
        clr_full = cf; clr_ovf = co;
        @(posedge clk);
        @(negedge clk);
        clr_full = '0; clr_ovf = '0;
    endtask

    task automatic read_id(input logic b, input logic [ID_W-1:0] exp, input string req);
        #3 rd_sel = b;
        #1 chk(req, rd_id, exp);
        @(negedge clk);
    endtask

    // monitor: every newly set full flag pops one expected item
    initial begin
        logic [1:0] pf;
        exp_t e;
        pf = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                for (int b = 0; b < 2; b++) begin
                    if (full[b] && !pf[b]) begin
                        rd_sel = b[0];
                        #1;
                        if (q.size() == 0) begin
                            chk("R2 unexpected load", 128'(b), 128'(-1));
                        end else begin
                            e = q.pop_front();
                            chk("R11 target buffer", 128'(b), 128'(e.bsel));
                            chk("R2 id",   rd_id,   e.id);
                            chk("R2 ext",  rd_ext,  e.ext);
                            chk("R2 rtr",  rd_rtr,  e.rtr);
                            chk("R2 dlc",  rd_dlc,  e.dlc);
                            chk("R2 data", rd_data, e.data);
                            chk("R2 fidx", rd_fidx, e.fidx);
                        end
                    end
                end
            end
            pf = full;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 full", full, 2'b00);
        chk("R1 ovf",  ovf,  2'b00);
        chk("R1 irq",  irq,  2'b00);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 full after reset", full, 2'b00);
        irq_en = 2'b11;

        send(1, 0, 29'h123, 0, 0, 4'd8, 64'h1122334455667788, 1, 3'd2, 0, 3'd0, 0, 3'd2);
        chk("R2 full0 set", full, 2'b01);
        chk("R5 irq0", irq, 2'b01);

        send(1, 0, 29'h1ABCDEF, 1, 1, 4'd0, 64'hDEAD0000BEEF0000, 1, 3'd1, 1, 3'd5, 1, 3'd5);
        chk("R8 fall to buf1", full, 2'b11);
        chk("R8 no ovf", ovf, 2'b00);

        send(1, 0, 29'h7, 0, 0, 4'd1, 64'h1, 1, 3'd0, 0, 3'd0, -1, 3'd0);
        chk("R10 ovf0 set", ovf, 2'b01);
        chk("R4 still full", full, 2'b11);
        read_id(1'b0, 29'h123, "R4 buf0 kept");
        send(1, 0, 29'h8, 0, 0, 4'd1, 64'h2, 0, 3'd0, 1, 3'd3, -1, 3'd0);
        chk("R10 ovf1 set", ovf, 2'b11);
        pulse(2'b00, 2'b11);
        chk("R10 ovf cleared", ovf, 2'b00);
        pulse(2'b01, 2'b00);
        chk("R4 full0 released", full, 2'b10);
        chk("R5 irq follows", irq, 2'b10);
        pulse(2'b10, 2'b00);

        send(1, 0, 29'h55, 0, 0, 4'd2, 64'hABCD, 1, 3'd3, 1, 3'd4, 0, 3'd3);
        chk("R6 only buf0", full, 2'b01);

        roll_en = 1'b1;
        send(1, 0, 29'h66, 1, 0, 4'd3, 64'h5566, 1, 3'd6, 0, 3'd1, 1, 3'd6);
        chk("R7 rolled", full, 2'b11);
        chk("R7 no ovf", ovf, 2'b00);
        send(1, 0, 29'h77, 0, 0, 4'd4, 64'h77, 1, 3'd6, 0, 3'd0, -1, 3'd0);
        chk("R10 rollover drop", ovf, 2'b10);
        pulse(2'b11, 2'b11);
        roll_en = 1'b0;

        mode0 = 2'b01;
        send(1, 0, 29'h10, 1, 0, 4'd1, 64'h10, 1, 3'd1, 0, 3'd0, -1, 3'd0);
        chk("R3 std mode rejects ext", full, 2'b00);
        send(1, 0, 29'h11, 0, 0, 4'd1, 64'h11, 1, 3'd1, 0, 3'd0, 0, 3'd1);
        chk("R3 std mode takes std", full, 2'b01);
        pulse(2'b01, 2'b00);
        mode0 = 2'b10;
        send(1, 0, 29'h12, 0, 0, 4'd1, 64'h12, 1, 3'd1, 0, 3'd0, -1, 3'd0);
        chk("R3 ext mode rejects std", full, 2'b00);
        send(1, 0, 29'h13, 1, 1, 4'd1, 64'h13, 1, 3'd0, 0, 3'd0, 0, 3'd0);
        chk("R3 ext mode takes ext", full, 2'b01);
        pulse(2'b01, 2'b00);
        mode0 = 2'b11;
        send(1, 0, 29'h14, 0, 0, 4'd5, 64'h14, 0, 3'd7, 0, 3'd0, 0, 3'd7);
        chk("R3 all mode ignores filter", full, 2'b01);
        pulse(2'b01, 2'b00);

        send(0, 1, 29'h15, 0, 0, 4'd2, 64'h15, 0, 3'd4, 0, 3'd0, 0, 3'd4);
        chk("R9 partial kept in mode 11", full, 2'b01);
        pulse(2'b01, 2'b00);
        mode0 = 2'b00;
        send(0, 1, 29'h16, 0, 0, 4'd2, 64'h16, 1, 3'd4, 0, 3'd0, -1, 3'd0);
        chk("R9 error ignored in mode 00", full, 2'b00);
        chk("R9 no ovf", ovf, 2'b00);

        irq_en = 2'b10;
        send(1, 0, 29'h17, 0, 0, 4'd1, 64'h17, 1, 3'd2, 0, 3'd0, 0, 3'd2);
        chk("R5 irq masked", irq, 2'b00);
        send(1, 0, 29'h18, 0, 0, 4'd1, 64'h18, 0, 3'd0, 1, 3'd6, 1, 3'd6);
        chk("R5 irq1 enabled", irq, 2'b10);
        read_id(1'b1, 29'h18, "R11 read buf1");
        read_id(1'b0, 29'h17, "R11 read buf0");

        repeat (2) @(negedge clk);
        chk("R2 all expected loads seen", 128'(q.size()), 128'(0));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule